// File: doc/BRIEF.md
# Block-RAM Bus Slave Controller

This block sits on a processor bus whose transactions split into an address phase and a data phase. It maps a byte-addressed window onto an external synchronous block RAM. A request is offered with a valid strobe, a byte address, byte enables, a read/write flag, a transfer kind and a burst length. The controller answers in the same cycle with an address acknowledge, or it stays silent. Once it acknowledges, it drives the RAM enable, per-lane write enables, word address and write data for each beat. It returns read data with a one-cycle pipeline that matches the RAM latency. Each data phase ends with a write or read completion strobe.

Four transfer kinds are accepted: single beat, 4-word cacheline, 8-word cacheline and fixed-length burst. Cacheline reads wrap inside their line. Two parameters change how the decoder and the qualifier behave. One replaces the window compare with "accept everything" for a point-to-point link. The other limits the slave to single beats.

A three-state machine sequences the data phase. It has three transitions:
- `ST_IDLE` to `ST_WRITE` on an accepted write (*grant-write*).
- `ST_IDLE` to `ST_READ` on an accepted read (*grant-read*).
- `ST_WRITE` or `ST_READ` back to `ST_IDLE` on the final beat (*last-beat*).

Every other cycle holds the current state.

Top module: `bram_slave_ctrl`

## Requirements
- R1: With `P2P`=0, `addr_ack` rises only for addresses from `BASE_ADDR` to `BASE_ADDR + 2**WIN_LOG2 - 1`. A request outside that range is not acknowledged, and no data phase follows it: `mem_en`, `wr_dack` and `rd_dack` stay low.
- R2: With `P2P`=1, every request of a supported kind is acknowledged, whatever its address.
- R3: `addr_ack` is combinational. It is high in a cycle where the controller is idle and `req_valid` carries an accepted request. The data phase starts in the next cycle, and no acknowledge is given while a data phase issues beats.
- R4: Read data arrives one cycle after each read beat is issued. `rd_dack` is high in that cycle and `rd_data` carries `mem_rdata`. `rd_data` is zero in every cycle where `rd_dack` is low.
- R5: During a single-beat write, `mem_we` equals the captured `req_be`. Bit i of `mem_we` governs byte `mem_wdata[DW-1-8i -: 8]`, so bit 0 is the lowest address, carried on the most significant bits. Cacheline and burst writes assert all bits of `mem_we`.
- R6: Reads ignore `req_be`, and `mem_we` stays all-zero on every read beat.
- R7: A single-beat write asserts `wr_dack` and `wr_comp` in one cycle. A single-beat read asserts `rd_dack` and `rd_comp` in one cycle. In every transfer the completion strobe appears only with the final data acknowledge.
- R8: `req_kind` 01 selects a 16-byte line and `req_kind` 10 selects a 32-byte line. At 64 bits these take 2 and 4 beats. A line read starts at the requested word and wraps inside the line. A line write whose address is not aligned to the line size is not acknowledged.
- R9: `req_kind` 11 is a fixed burst of `req_len`+1 beats, from 2 to 16, at linearly rising word addresses. A burst with `req_len`=0 is not acknowledged.
- R10: With `BURST_EN`=0, only `req_kind` 00 is acknowledged.
- R11: `mem_addr` carries the byte address shifted right by log2 of the bytes per word, and it advances by one word for each beat.
- R12: A new request can be acknowledged in the same cycle as the final `rd_dack`/`rd_comp` of the previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | DATA_W/8 | Byte enables, bit 0 = lowest address |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_kind | input | 2 | 00 single, 01 16-byte line, 10 32-byte line, 11 burst |
| req_len | input | LEN_W | Burst beats minus one |
| wr_data | input | DATA_W | Write data of the current beat |
| addr_ack | output | 1 | Address phase accepted |
| wr_dack | output | 1 | Write beat taken |
| wr_comp | output | 1 | Write data phase complete |
| rd_dack | output | 1 | Read beat valid on rd_data |
| rd_comp | output | 1 | Read data phase complete |
| rd_data | output | DATA_W | Read data |
| mem_en | output | 1 | RAM enable |
| mem_we | output | DATA_W/8 | RAM per-lane write enables |
| mem_addr | output | ADDR_W-log2(DATA_W/8) | RAM word address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after enable |

## Verification
The acknowledge of a new address phase can fall in the same cycle as the final data acknowledge and completion of a read that is still draining through the read pipeline. The bench provokes this directly. It offers a single write during the very cycle a single read's result is due. Then it judges that `addr_ack`, `rd_dack` and `rd_comp` are all high together, and that both the returned read data and the later write land on the expected words.

// File: rtl/bram_slv_pkg.sv
package bram_slv_pkg;

    typedef enum logic [1:0] {
        XK_SINGLE = 2'b00,
        XK_LINE4  = 2'b01,
        XK_LINE8  = 2'b10,
        XK_BURST  = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WRITE = 2'b01,
        ST_READ  = 2'b10
    } slv_state_e;

endpackage

// File: rtl/bram_win_decode.sv
module bram_win_decode #(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int              WIN_LOG2  = 12,
    parameter bit              P2P       = 1'b0
) (
    input  logic [ADDR_W-WIN_LOG2-1:0] addr_hi,
    output logic                       hit
);

    generate
        if (P2P) begin : g_p2p
            // Point-to-point link: every address belongs to this slave.
            logic unused_hi;
            assign unused_hi = ^addr_hi;
            assign hit       = 1'b1;
        end else begin : g_shared
            localparam logic [ADDR_W-WIN_LOG2-1:0] BASE_HI = BASE_ADDR[ADDR_W-1:WIN_LOG2];
            assign hit = (addr_hi == BASE_HI);
        end
    endgenerate

endmodule

// File: rtl/bram_xfer_qualify.sv
module bram_xfer_qualify
    import bram_slv_pkg::*;
#(
    parameter int BYTES    = 8,
    parameter bit BURST_EN = 1'b1,
    parameter int LEN_W    = 4,
    parameter int WORD_AW  = 29,
    parameter int CNT_W    = LEN_W + 1
) (
    input  xfer_kind_e         kind,
    input  logic               rnw,
    input  logic [LEN_W-1:0]   len,
    input  logic [4:0]         addr_lo,
    input  logic [BYTES-1:0]   be,
    output logic               ok,
    output logic [CNT_W-1:0]   beats_m1,
    output logic [WORD_AW-1:0] wrap_mask,
    output logic [BYTES-1:0]   we_pat
);

    localparam int LINE4_BEATS = 16 / BYTES;
    localparam int LINE8_BEATS = 32 / BYTES;

    always_comb begin
        ok        = 1'b0;
        beats_m1  = '0;
        wrap_mask = '0;
        we_pat    = '1;
        unique case (kind)
            XK_SINGLE: begin
                ok     = 1'b1;
                we_pat = be;
            end
            XK_LINE4: begin
                ok        = BURST_EN && (rnw || (addr_lo[3:0] == 4'd0));
                beats_m1  = CNT_W'(LINE4_BEATS - 1);
                wrap_mask = WORD_AW'(LINE4_BEATS - 1);
            end
            XK_LINE8: begin
                ok        = BURST_EN && (rnw || (addr_lo == 5'd0));
                beats_m1  = CNT_W'(LINE8_BEATS - 1);
                wrap_mask = WORD_AW'(LINE8_BEATS - 1);
            end
            XK_BURST: begin
                ok        = BURST_EN && (len != '0);
                beats_m1  = CNT_W'(len);
                wrap_mask = '1;
            end
            default: ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/bram_beat_seq.sv
module bram_beat_seq #(
    parameter int WORD_AW = 29,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [WORD_AW-1:0] start_word,
    input  logic [CNT_W-1:0]   beats_m1,
    input  logic [WORD_AW-1:0] wrap_mask,
    input  logic               step,
    output logic [WORD_AW-1:0] word,
    output logic               last
);

    logic [WORD_AW-1:0] word_q;
    logic [WORD_AW-1:0] mask_q;
    logic [CNT_W-1:0]   left_q;
    logic [WORD_AW-1:0] word_inc;
    logic [WORD_AW-1:0] word_nxt;

    // Masked bits roll over, unmasked bits hold: a line wraps, a burst counts on.
    assign word_inc = word_q + 1'b1;
    assign word_nxt = (word_q & ~mask_q) | (word_inc & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            mask_q <= '0;
            left_q <= '0;
        end else if (load) begin
            word_q <= start_word;
            mask_q <= wrap_mask;
            left_q <= beats_m1;
        end else if (step && (left_q != '0)) begin
            word_q <= word_nxt;
            left_q <= left_q - 1'b1;
        end
    end

    assign word = word_q;
    assign last = (left_q == '0);

    AST_BEAT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (step && !last && !load) |=> (word != $past(word)));  // R11

endmodule

// File: rtl/bram_slave_ctrl.sv
module bram_slave_ctrl
    import bram_slv_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 64,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0002_0000,
    parameter int                WIN_LOG2  = 12,
    parameter bit                P2P       = 1'b0,
    parameter bit                BURST_EN  = 1'b1,
    parameter int                LEN_W     = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   req_valid,
    input  logic [ADDR_W-1:0]                      req_addr,
    input  logic [DATA_W/8-1:0]                    req_be,
    input  logic                                   req_rnw,
    input  logic [1:0]                             req_kind,
    input  logic [LEN_W-1:0]                       req_len,
    input  logic [DATA_W-1:0]                      wr_data,
    output logic                                   addr_ack,
    output logic                                   wr_dack,
    output logic                                   wr_comp,
    output logic                                   rd_dack,
    output logic                                   rd_comp,
    output logic [DATA_W-1:0]                      rd_data,
    output logic                                   mem_en,
    output logic [DATA_W/8-1:0]                    mem_we,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0]     mem_addr,
    output logic [DATA_W-1:0]                      mem_wdata,
    input  logic [DATA_W-1:0]                      mem_rdata
);

    localparam int BYTES   = DATA_W / 8;
    localparam int OFF     = $clog2(BYTES);
    localparam int WORD_AW = ADDR_W - OFF;
    localparam int CNT_W   = LEN_W + 1;

    localparam logic [ADDR_W:0] WIN_ONE = 1;
    localparam logic [ADDR_W:0] WIN_LO  = {1'b0, BASE_ADDR};
    localparam logic [ADDR_W:0] WIN_HI  = WIN_LO + (WIN_ONE << WIN_LOG2) - WIN_ONE;

    slv_state_e          state_q, state_d;
    logic                win_hit;
    logic                kind_ok;
    logic                accept;
    logic [CNT_W-1:0]    beats_m1;
    logic [WORD_AW-1:0]  wrap_mask;
    logic [BYTES-1:0]    we_pat;
    logic [BYTES-1:0]    we_q;
    logic [WORD_AW-1:0]  cur_word;
    logic                beat_last;
    logic                step;
    logic                rd_vld_q;
    logic                rd_last_q;

    bram_win_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .WIN_LOG2  (WIN_LOG2),
        .P2P       (P2P)
    ) u_win (
        .addr_hi (req_addr[ADDR_W-1:WIN_LOG2]),
        .hit     (win_hit)
    );

    bram_xfer_qualify #(
        .BYTES    (BYTES),
        .BURST_EN (BURST_EN),
        .LEN_W    (LEN_W),
        .WORD_AW  (WORD_AW),
        .CNT_W    (CNT_W)
    ) u_qual (
        .kind      (xfer_kind_e'(req_kind)),
        .rnw       (req_rnw),
        .len       (req_len),
        .addr_lo   (req_addr[4:0]),
        .be        (req_be),
        .ok        (kind_ok),
        .beats_m1  (beats_m1),
        .wrap_mask (wrap_mask),
        .we_pat    (we_pat)
    );

    assign accept = (state_q == ST_IDLE) && req_valid && win_hit && kind_ok;
    assign step   = (state_q != ST_IDLE);

    bram_beat_seq #(
        .WORD_AW (WORD_AW),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .start_word (req_addr[ADDR_W-1:OFF]),
        .beats_m1   (beats_m1),
        .wrap_mask  (wrap_mask),
        .step       (step),
        .word       (cur_word),
        .last       (beat_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)    state_d = req_rnw ? ST_READ : ST_WRITE;
            ST_WRITE: if (beat_last) state_d = ST_IDLE;
            ST_READ:  if (beat_last) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Captured lane enables and read-return pipeline
    always_ff @(posedge clk) begin
        if (rst) begin
            we_q      <= '0;
            rd_vld_q  <= 1'b0;
            rd_last_q <= 1'b0;
        end else begin
            if (accept) we_q <= we_pat;
            rd_vld_q  <= (state_q == ST_READ);
            rd_last_q <= (state_q == ST_READ) && beat_last;
        end
    end

    // Outputs
    always_comb begin
        addr_ack = 1'b0;
        mem_en   = 1'b0;
        mem_we   = '0;
        wr_dack  = 1'b0;
        wr_comp  = 1'b0;
        unique case (state_q)
            ST_IDLE:  addr_ack = accept;
            ST_WRITE: begin
                mem_en  = 1'b1;
                mem_we  = we_q;
                wr_dack = 1'b1;
                wr_comp = beat_last;
            end
            ST_READ:  mem_en = 1'b1;
            default:  mem_en = 1'b0;
        endcase
    end

    assign mem_addr  = cur_word;
    assign mem_wdata = wr_data;
    assign rd_dack   = rd_vld_q;
    assign rd_comp   = rd_last_q;
    assign rd_data   = rd_vld_q ? mem_rdata : '0;

    AST_ACK_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (!P2P && addr_ack) |-> (({1'b0, req_addr} >= WIN_LO) && ({1'b0, req_addr} <= WIN_HI)));  // R1
    AST_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        addr_ack |-> !mem_en);  // R3
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_dack |-> ($past(mem_en) && ($past(mem_we) == '0)));  // R4
    AST_RD_DATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd_dack |-> (rd_data == '0));  // R4
    AST_READ_NO_WE: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !wr_dack) |-> (mem_we == '0));  // R6
    AST_WCOMP_WITH_DACK: assert property (@(posedge clk) disable iff (rst)
        wr_comp |-> wr_dack);  // R7
    AST_RCOMP_WITH_DACK: assert property (@(posedge clk) disable iff (rst)
        rd_comp |-> rd_dack);  // R7
    AST_LINE_WR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (addr_ack && !req_rnw && (req_kind == 2'b10)) |-> (req_addr[4:0] == 5'd0));  // R8
    AST_BURST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (addr_ack && (req_kind == 2'b11)) |-> (req_len != '0));  // R9
    AST_SINGLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!BURST_EN && addr_ack) |-> (req_kind == 2'b00));  // R10

endmodule

// File: tb/bram_slave_ctrl_tb.sv
`timescale 1ns/1ps
module bram_slave_ctrl_tb;

    localparam int          DW    = 64;
    localparam int          NB    = 8;
    localparam int          MAW   = 29;
    localparam int          WORDS = 512;
    localparam logic [31:0] BASE  = 32'h0002_0000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst;
    logic          req_valid;
    logic [31:0]   req_addr;
    logic [NB-1:0] req_be;
    logic          req_rnw;
    logic [1:0]    req_kind;
    logic [3:0]    req_len;
    logic [DW-1:0] wr_data;
    logic          addr_ack, wr_dack, wr_comp, rd_dack, rd_comp, mem_en;
    logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
    logic [NB-1:0] mem_we;
    logic [MAW-1:0] mem_addr;

    logic          p_ack, p_wd, p_wc, p_rd, p_rc, p_en;
    logic [DW-1:0] p_rdata, p_wdata;
    logic [NB-1:0] p_we;
    logic [MAW-1:0] p_addr;
    logic          s_ack, s_wd, s_wc, s_rd, s_rc, s_en;
    logic [DW-1:0] s_rdata, s_wdata;
    logic [NB-1:0] s_we;
    logic [MAW-1:0] s_addr;

    bram_slave_ctrl #(.BASE_ADDR(BASE), .WIN_LOG2(12), .P2P(1'b0), .BURST_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be),
        .req_rnw(req_rnw), .req_kind(req_kind), .req_len(req_len), .wr_data(wr_data),
        .addr_ack(addr_ack), .wr_dack(wr_dack), .wr_comp(wr_comp), .rd_dack(rd_dack),
        .rd_comp(rd_comp), .rd_data(rd_data), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

    bram_slave_ctrl #(.BASE_ADDR(BASE), .WIN_LOG2(12), .P2P(1'b1), .BURST_EN(1'b1)) u_p2p (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be),
        .req_rnw(req_rnw), .req_kind(req_kind), .req_len(req_len), .wr_data(wr_data),
        .addr_ack(p_ack), .wr_dack(p_wd), .wr_comp(p_wc), .rd_dack(p_rd),
        .rd_comp(p_rc), .rd_data(p_rdata), .mem_en(p_en), .mem_we(p_we),
        .mem_addr(p_addr), .mem_wdata(p_wdata), .mem_rdata('0));

    bram_slave_ctrl #(.BASE_ADDR(BASE), .WIN_LOG2(12), .P2P(1'b0), .BURST_EN(1'b0)) u_sgl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be),
        .req_rnw(req_rnw), .req_kind(req_kind), .req_len(req_len), .wr_data(wr_data),
        .addr_ack(s_ack), .wr_dack(s_wd), .wr_comp(s_wc), .rd_dack(s_rd),
        .rd_comp(s_rc), .rd_data(s_rdata), .mem_en(s_en), .mem_we(s_we),
        .mem_addr(s_addr), .mem_wdata(s_wdata), .mem_rdata('0));

    // Synchronous RAM with one-cycle read latency, big-endian lanes.
    logic [DW-1:0] ram    [WORDS];
    logic [DW-1:0] shadow [WORDS];
    always @(posedge clk) begin
        if (mem_en) begin
            for (int i = 0; i < NB; i++)
                if (mem_we[i]) ram[mem_addr[8:0]][DW-1-8*i -: 8] <= mem_wdata[DW-1-8*i -: 8];
            mem_rdata <= ram[mem_addr[8:0]];
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_ack(logic [31:0] a, logic rnw, logic [1:0] k, logic [3:0] len, bit p2p, bit ben);
        bit inwin;
        bit sup;
        inwin = p2p || (a[31:12] == BASE[31:12]);
        case (k)
            2'b00:   sup = 1'b1;
            2'b01:   sup = ben && (rnw || (a[3:0] == 4'd0));
            2'b10:   sup = ben && (rnw || (a[4:0] == 5'd0));
            default: sup = ben && (len != 4'd0);
        endcase
        return inwin && sup;
    endfunction

    function automatic int beats_of(logic [1:0] k, logic [3:0] len);
        case (k)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return int'(len) + 1;
        endcase
    endfunction

    function automatic logic [MAW-1:0] word_at(logic [31:0] a, logic [1:0] k, int b);
        int unsigned w;
        int unsigned ln;
        w = a >> 3;
        if (k == 2'b01 || k == 2'b10) begin
            ln = (k == 2'b01) ? 2 : 4;
            return MAW'((w / ln) * ln + ((w % ln) + b) % ln);
        end
        return MAW'(w + b);
    endfunction

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NB-1:0] we);
        logic [DW-1:0] r;
        r = old;
        for (int i = 0; i < NB; i++)
            if (we[i]) r[DW-1-8*i -: 8] = nw[DW-1-8*i -: 8];
        return r;
    endfunction

    task automatic xfer(input string tag, input logic rnw, input logic [1:0] kind, input logic [3:0] len,
                        input logic [31:0] addr, input logic [NB-1:0] be, input bit aux);
        bit e_ack;
        int n;
        logic [MAW-1:0] w;
        logic [DW-1:0] d;
        logic [NB-1:0] e_we;
        e_ack = exp_ack(addr, rnw, kind, len, 1'b0, 1'b1);
        n = beats_of(kind, len);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_rnw = rnw; req_kind = kind; req_len = len; req_be = be;
        #1;
        chk(tag, "R3 addr_ack", addr_ack, e_ack);
        if (aux) begin
            chk(tag, "R2 p2p addr_ack", p_ack, exp_ack(addr, rnw, kind, len, 1'b1, 1'b1));
            chk(tag, "R10 single-only addr_ack", s_ack, exp_ack(addr, rnw, kind, len, 1'b0, 1'b0));
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!e_ack) begin
            chk(tag, "R1 no data phase", {61'd0, mem_en, wr_dack, rd_dack}, 64'd0);
        end else if (!rnw) begin
            e_we = (kind == 2'b00) ? be : '1;
            for (int b = 0; b < n; b++) begin
                if (b > 0) @(negedge clk);
                d = {$urandom, $urandom};
                wr_data = d;
                w = word_at(addr, kind, b);
                #1;
                chk(tag, "R7 wr_dack", wr_dack, 1'b1);
                chk(tag, "R7 wr_comp", wr_comp, (b == n - 1));
                chk(tag, "R11 write mem_addr", mem_addr, w);
                chk(tag, "R5 mem_we", mem_we, e_we);
                shadow[w[8:0]] = merge(shadow[w[8:0]], d, e_we);
                @(posedge clk);
            end
        end else begin
            for (int c = 0; c <= n; c++) begin
                if (c > 0) @(negedge clk);
                if (c < n) begin
                    chk(tag, "R8 R9 R11 read mem_addr", mem_addr, word_at(addr, kind, c));
                    chk(tag, "R6 read mem_we", mem_we, '0);
                end
                if (c == 0) begin
                    chk(tag, "R4 rd_dack before latency", rd_dack, 1'b0);
                    chk(tag, "R4 rd_data quiet", rd_data, '0);
                end else begin
                    w = word_at(addr, kind, c - 1);
                    chk(tag, "R4 rd_dack", rd_dack, 1'b1);
                    chk(tag, "R4 rd_data", rd_data, shadow[w[8:0]]);
                    chk(tag, "R7 rd_comp", rd_comp, (c == n));
                end
                @(posedge clk);
            end
        end
        if (aux) repeat (20) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [1:0]  k;
        logic [3:0]  ln;
        logic [31:0] a;
        logic        rw;
        logic [NB-1:0] bb;
        logic [DW-1:0] d;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < WORDS; i++) begin
            ram[i] = '0;
            shadow[i] = '0;
        end
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_be = '0; req_rnw = 1'b0;
        req_kind = 2'b00; req_len = '0; wr_data = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3", "reset outputs idle", {58'd0, addr_ack, mem_en, wr_dack, rd_dack, wr_comp, rd_comp}, 64'd0);
        chk("R4", "reset rd_data", rd_data, '0);

        // R1 window edges
        xfer("R1", 1'b0, 2'b00, 4'd0, BASE + 32'hFF8, 8'hFF, 1'b1);
        xfer("R1", 1'b1, 2'b00, 4'd0, BASE + 32'hFFF, 8'h00, 1'b1);
        xfer("R1", 1'b1, 2'b00, 4'd0, BASE - 32'd8,   8'hFF, 1'b1);
        xfer("R1", 1'b0, 2'b00, 4'd0, BASE + 32'h1000, 8'hFF, 1'b1);
        xfer("R1", 1'b1, 2'b00, 4'd0, BASE,           8'h00, 1'b1);

        // R5 lane mapping: single lanes then read back
        xfer("R5", 1'b0, 2'b00, 4'd0, BASE + 32'h40, 8'h01, 1'b1);
        xfer("R5", 1'b0, 2'b00, 4'd0, BASE + 32'h40, 8'h80, 1'b1);
        xfer("R6", 1'b1, 2'b00, 4'd0, BASE + 32'h40, 8'h00, 1'b1);

        // R9 burst fills words 8..15, then R8 wrapping line read from word 10
        xfer("R9", 1'b0, 2'b11, 4'd7, BASE + 32'h40, 8'h00, 1'b1);
        xfer("R8", 1'b1, 2'b10, 4'd0, BASE + 32'h50, 8'h00, 1'b1);
        xfer("R8", 1'b1, 2'b01, 4'd0, BASE + 32'h48, 8'h00, 1'b1);
        xfer("R8", 1'b0, 2'b01, 4'd0, BASE + 32'h48, 8'h00, 1'b1);
        xfer("R8", 1'b0, 2'b10, 4'd0, BASE + 32'h70, 8'h00, 1'b1);
        xfer("R8", 1'b0, 2'b01, 4'd0, BASE + 32'h60, 8'h00, 1'b1);
        xfer("R9", 1'b0, 2'b11, 4'd0, BASE + 32'h80, 8'h00, 1'b1);
        xfer("R9", 1'b0, 2'b11, 4'd15, BASE + 32'h100, 8'h00, 1'b1);
        xfer("R9", 1'b1, 2'b11, 4'd15, BASE + 32'h100, 8'h00, 1'b1);
        xfer("R2", 1'b1, 2'b11, 4'd3, 32'h8000_0000, 8'h00, 1'b1);

        // R12 new address phase in the cycle of the final read completion
        @(negedge clk);
        req_valid = 1'b1; req_addr = BASE + 32'h40; req_rnw = 1'b1; req_kind = 2'b00; req_len = '0; req_be = '0;
        #1 chk("R12", "first addr_ack", addr_ack, 1'b1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12", "issue mem_en", mem_en, 1'b1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b1; req_addr = BASE + 32'h88; req_rnw = 1'b0; req_be = 8'hFF;
        #1;
        chk("R12", "overlap addr_ack", addr_ack, 1'b1);
        chk("R12", "overlap rd_comp", rd_comp, 1'b1);
        chk("R12", "overlap rd_dack", rd_dack, 1'b1);
        chk("R12", "overlap rd_data", rd_data, shadow[8]);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        d = {$urandom, $urandom};
        wr_data = d;
        #1;
        chk("R12", "next wr_comp", {62'd0, wr_dack, wr_comp}, 64'd3);
        chk("R12", "next mem_addr", mem_addr, MAW'((BASE + 32'h88) >> 3));
        shadow[17] = d;
        @(posedge clk);
        repeat (20) @(posedge clk);
        xfer("R12", 1'b1, 2'b00, 4'd0, BASE + 32'h88, 8'h00, 1'b1);

        // Constrained random traffic
        for (int t = 0; t < 160; t++) begin
            k  = 2'($urandom % 4);
            ln = 4'($urandom % 16);
            rw = 1'($urandom % 2);
            bb = NB'($urandom);
            if (($urandom % 10) < 8) begin
                a = BASE + ((32'($urandom % 48)) << 3) + 32'($urandom % 8);
                if ((k == 2'b01 || k == 2'b10) && ($urandom % 4) != 0)
                    a = a & ((k == 2'b01) ? 32'hFFFF_FFF0 : 32'hFFFF_FFE0);
            end else begin
                a = $urandom;
            end
            xfer("R3", rw, k, ln, a, bb, 1'b1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule